// File: doc/BRIEF.md
# Peripheral Controller Register Front End

This block is the part of a peripheral controller that the processor sees. It decodes a small memory-mapped register window that holds a command register, a status word and a bank of general data registers. A write to the command register starts an operation on the device side: the block pulses a start strobe and presents an opcode. It then waits for the device to report completion, together with a result code. Software learns that the operation has finished in one of two ways. It can poll the done flag in the status word, or it can enable an interrupt that is raised on completion.

A three-state machine drives the progress flags. The state encoding is the {busy, done} pair itself:

| State | busy | done | Meaning |
|---|---|---|---|
| ST_IDLE | 0 | 0 | No operation since reset |
| ST_WORKING | 1 | 0 | Operation in progress |
| ST_FINISHED | 0 | 1 | Last operation complete |

The fourth combination, busy = 1 and done = 1, is the undefined state and is never produced.

The machine has three transitions:
- **launch**: ST_IDLE or ST_FINISHED to ST_WORKING, on a command write.
- **complete**: ST_WORKING to ST_FINISHED, on device completion.
- **reject**: ST_WORKING stays in ST_WORKING, on a command write, and flags an error.

Register word addresses:

| Address | Register |
|---|---|
| 0 | Command |
| 1 | Status |
| 2 to 2+N-1 | Data registers |

Command register fields: bit 0 is the interrupt enable, and bits 15:8 are the opcode. Status register fields: bit 0 is busy, bit 1 is done, bits 5:2 are the error code, and the remaining bits read as zero.

Top module: `devctl_regs`

## Requirements
- R1: After reset, the status, command and data registers all read 0, irq is 0 and dev_start is 0.
- R2: A command write in ST_IDLE or ST_FINISHED is the launch transition. It stores the word. In the next cycle dev_start is 1 for exactly one cycle, dev_op equals command bits 15:8, and the status reads busy=1, done=0, error=0.
- R3: Status bit 0 is busy, bit 1 is done and bits 5:2 are the error code. Busy and done are never both 1.
- R4: Completion (dev_done while ST_WORKING) moves the block to ST_FINISHED in the next cycle, with busy=0, done=1 and the error field equal to the dev_err value sampled with dev_done.
- R5: A command write in ST_WORKING (the reject transition) leaves the command register and dev_op unchanged and gives no dev_start. The block stays busy and the error field becomes 4'hF.
- R6: When command bit 0 is 1, irq goes to 1 in the cycle after completion. When command bit 0 is 0, irq stays 0 while done is still set.
- R7: A status read clears the pending interrupt, so irq is 0 in the following cycle. A completion in the same cycle as the status read wins, and irq becomes 1.
- R8: Data registers at addresses 2 to 2+N-1 can be written and read, and they are driven on dev_data (register i at bits i*16 and up). Writes to the status address have no effect, and unmapped addresses read 0.
- R9: dev_done outside ST_WORKING is ignored: the status word does not change.
- R10: A launch from ST_FINISHED clears done and any pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Word address |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Read data, combinational from the address |
| dev_start | output | 1 | One-cycle operation start strobe |
| dev_op | output | OPW (8) | Opcode of the accepted command |
| dev_data | output | N*DW (64) | Data registers, flattened |
| dev_done | input | 1 | Device completion strobe |
| dev_err | input | EW (4) | Device result code, valid with dev_done |
| irq | output | 1 | Completion interrupt |

## Verification
Every register update lands on the edge that samples the access. A command write, a completion or a status read therefore shows its effect one cycle later: dev_start, dev_op, the new status word and the rise or fall of irq all appear in that cycle. Read data is combinational, so the bench expects the state that was current before the read's own edge. The driver changes inputs 1 ns after a rising edge and queues the expected read value. The monitor pops the queue and compares on the falling edge of the same cycle. Strobe and interrupt checks are also taken on that falling edge, one cycle after the stimulus edge.

// File: rtl/devctl_pkg.sv
package devctl_pkg;
    // State encoding doubles as the {busy, done} status pair.
    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_FINISHED = 2'b01,
        ST_WORKING  = 2'b10
    } ctl_state_e;

    localparam int unsigned ADDR_CMD    = 0;
    localparam int unsigned ADDR_STATUS = 1;
    localparam int unsigned ADDR_DATA0  = 2;
endpackage

// File: rtl/devctl_seq.sv
module devctl_seq
    import devctl_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          dev_done,
    input  logic [EW-1:0] dev_err,
    output logic          busy,
    output logic          done,
    output logic [EW-1:0] err_code,
    output logic [DW-1:0] cmd_q,
    output logic          dev_start,
    output logic          launch,
    output logic          complete
);
    localparam logic [EW-1:0] BUSY_ERR = '1;

    ctl_state_e state_q, state_d;
    logic       reject;

    always_comb begin
        state_d  = state_q;
        launch   = 1'b0;
        reject   = 1'b0;
        complete = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FINISHED: begin
                if (cmd_wr) begin
                    launch  = 1'b1;
                    state_d = ST_WORKING;
                end
            end
            ST_WORKING: begin
                if (dev_done) begin
                    complete = 1'b1;
                    state_d  = ST_FINISHED;
                end
                if (cmd_wr) begin
                    reject = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            err_code  <= '0;
            dev_start <= 1'b0;
        end else begin
            dev_start <= launch;
            if (launch) begin
                cmd_q    <= cmd_wdata;
                err_code <= '0;
            end else if (complete) begin
                err_code <= dev_err;
            end else if (reject) begin
                err_code <= BUSY_ERR;
            end
        end
    end

    assign busy = state_q[1];
    assign done = state_q[0];

    a_r3_never_undefined: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr) |=> (dev_start && busy && !done && err_code == '0));
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dev_start |=> !dev_start);
    a_r5_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !dev_done) |=> (busy && err_code == BUSY_ERR && !dev_start && $stable(cmd_q)));
    a_r4_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dev_done) |=> (done && !busy && err_code == $past(dev_err)));
    a_r9_ignore_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_wr && dev_done) |=> $stable({busy, done, err_code}));
endmodule

// File: rtl/devctl_irq.sv
module devctl_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic complete,
    input  logic launch,
    input  logic stat_rd,
    input  logic ien,
    output logic irq
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                 pend_q <= 1'b0;
        else if (complete)          pend_q <= 1'b1;
        else if (launch || stat_rd) pend_q <= 1'b0;
    end

    assign irq = pend_q & ien;

    a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && ien) |=> irq);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !complete) |=> !irq);
    a_r10_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !irq);
endmodule

// File: rtl/devctl_dbank.sv
module devctl_dbank #(
    parameter int unsigned DW = 16,
    parameter int unsigned N  = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] regs [N]
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                                regs[i] <= '0;
            else if (wr_en && wr_idx == IW'(i))        regs[i] <= wdata;
        end
    end
endmodule

// File: rtl/devctl_regs.sv
module devctl_regs
    import devctl_pkg::*;
#(
    parameter int unsigned DW  = 16,
    parameter int unsigned AW  = 4,
    parameter int unsigned N   = 4,
    parameter int unsigned EW  = 4,
    parameter int unsigned OPW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            dev_start,
    output logic [OPW-1:0]  dev_op,
    output logic [N*DW-1:0] dev_data,
    input  logic            dev_done,
    input  logic [EW-1:0]   dev_err,
    output logic            irq
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    logic          hit_cmd, hit_stat, hit_data;
    logic [AW-1:0] off;
    logic [IW-1:0] idx;
    logic          busy, done, launch, complete;
    logic [EW-1:0] err_code;
    logic [DW-1:0] cmd_q;
    logic [DW-1:0] dregs [N];
    logic [DW-1:0] status_word;

    assign hit_cmd  = (bus_addr == AW'(ADDR_CMD));
    assign hit_stat = (bus_addr == AW'(ADDR_STATUS));
    assign off      = bus_addr - AW'(ADDR_DATA0);
    assign hit_data = (bus_addr >= AW'(ADDR_DATA0)) && (off < AW'(N));
    assign idx      = off[IW-1:0];

    devctl_seq #(.DW(DW), .EW(EW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (bus_sel && bus_wr && hit_cmd),
        .cmd_wdata (bus_wdata),
        .dev_done  (dev_done),
        .dev_err   (dev_err),
        .busy      (busy),
        .done      (done),
        .err_code  (err_code),
        .cmd_q     (cmd_q),
        .dev_start (dev_start),
        .launch    (launch),
        .complete  (complete)
    );

    devctl_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .complete (complete),
        .launch   (launch),
        .stat_rd  (bus_sel && !bus_wr && hit_stat),
        .ien      (cmd_q[0]),
        .irq      (irq)
    );

    devctl_dbank #(.DW(DW), .N(N)) u_dbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_sel && bus_wr && hit_data),
        .wr_idx (idx),
        .wdata  (bus_wdata),
        .regs   (dregs)
    );

    for (genvar i = 0; i < N; i++) begin : g_flat
        assign dev_data[i*DW +: DW] = dregs[i];
    end

    assign dev_op      = cmd_q[DW-1 -: OPW];
    assign status_word = {{(DW-EW-2){1'b0}}, err_code, done, busy};

    always_comb begin
        bus_rdata = '0;
        if (hit_cmd)       bus_rdata = cmd_q;
        else if (hit_stat) bus_rdata = status_word;
        else if (hit_data) bus_rdata = dregs[idx];
    end

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_cmd && !hit_stat && !hit_data) |-> bus_rdata == '0);
    a_r3_status_pair: assert property (@(posedge clk) disable iff (!rst_n)
        hit_stat |-> bus_rdata[1:0] != 2'b11);
endmodule

// File: tb/devctl_regs_test.sv
`timescale 1ns/1ps
module devctl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        dev_start;
    logic [7:0]  dev_op;
    logic [63:0] dev_data;
    logic        dev_done = 1'b0;
    logic [3:0]  dev_err = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit ended  = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    devctl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_start(dev_start), .dev_op(dev_op), .dev_data(dev_data),
        .dev_done(dev_done), .dev_err(dev_err), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && bus_sel && !bus_wr && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
        end
    end

    task automatic step();
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; dev_done = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        dev_done = 1'b0;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        @(posedge clk); #1;
        dev_done = 1'b0;
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    endtask

    task automatic finish_op(input logic [3:0] e);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        dev_done = 1'b1; dev_err = e;
        step();
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", 64'(irq), 0);
        chk("R1 dev_start", 64'(dev_start), 0);
        chk("R1 dev_data", dev_data, 0);
        rd(4'd1, 16'h0000, "R1 status");
        rd(4'd0, 16'h0000, "R1 command");
        rd(4'd2, 16'h0000, "R1 data0");

        // R8 data bank, status write ignored, unmapped read
        wr(4'd2, 16'hA5A5);
        wr(4'd5, 16'h1234);
        wr(4'd1, 16'hFFFF);
        rd(4'd2, 16'hA5A5, "R8 data0");
        rd(4'd5, 16'h1234, "R8 data3");
        rd(4'd1, 16'h0000, "R8 status write ignored");
        rd(4'd7, 16'h0000, "R8 unmapped");
        step();
        chk("R8 dev_data", dev_data, 64'h1234_0000_0000_A5A5);

        // R2 launch from idle
        wr(4'd0, 16'h3C01);
        step();
        @(negedge clk);
        chk("R2 dev_start", 64'(dev_start), 1);
        chk("R2 dev_op", 64'(dev_op), 64'h3C);
        step();
        @(negedge clk);
        chk("R2 strobe single", 64'(dev_start), 0);
        rd(4'd1, 16'h0001, "R2 R3 status working");

        // R5 reject while working
        wr(4'd0, 16'h5500);
        step();
        @(negedge clk);
        chk("R5 no start", 64'(dev_start), 0);
        chk("R5 dev_op kept", 64'(dev_op), 64'h3C);
        rd(4'd1, 16'h003D, "R5 status busy err");
        rd(4'd0, 16'h3C01, "R5 command kept");

        // R4 completion, R6 interrupt, R7 read clear
        finish_op(4'h6);
        @(negedge clk);
        chk("R6 irq raised", 64'(irq), 1);
        rd(4'd1, 16'h001A, "R4 status finished");
        step();
        @(negedge clk);
        chk("R7 irq cleared", 64'(irq), 0);

        // R9 stray completion ignored
        finish_op(4'h3);
        rd(4'd1, 16'h001A, "R9 status unchanged");

        // R10 launch from finished, R6 gating with enable off
        wr(4'd0, 16'h7700);
        rd(4'd1, 16'h0001, "R10 done cleared");
        finish_op(4'h0);
        @(negedge clk);
        chk("R6 irq gated", 64'(irq), 0);
        rd(4'd1, 16'h0002, "R6 done without irq");

        // R10 pending interrupt dropped by new launch
        wr(4'd0, 16'h0101);
        step();
        finish_op(4'h1);
        @(negedge clk);
        chk("R10 irq before relaunch", 64'(irq), 1);
        wr(4'd0, 16'h0201);
        step();
        @(negedge clk);
        chk("R10 irq cleared by launch", 64'(irq), 0);

        // R7 completion coinciding with status read wins
        @(posedge clk); #1;
        exp_q.push_back(16'h0001); tag_q.push_back("R7 read during completion");
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd1;
        dev_done = 1'b1; dev_err = 4'h2;
        step();
        @(negedge clk);
        chk("R7 completion wins", 64'(irq), 1);
        rd(4'd1, 16'h000A, "R4 status err 2");
        step();
        step();
        summary();
    end
endmodule